// File: doc/BRIEF.md
# Timed Solenoid Valve Sequencer

This block drives one solenoid valve through two power switches. When an open request arrives, the block first closes the supply-connect switch and waits a fixed settle time. It then closes the actuating switch for a host-programmed open window. Release runs in the opposite order: the actuating switch opens, the settle time passes again, and the supply-connect switch opens last. A request that arrives while the window is running restarts the window with the new duration.

The valve reports back in two ways. A voltage comparator shows whether the coil is energised. The valve position contacts are filtered by a debouncer clocked from a 1 ms sample tick. Both readings appear in a live status word. A sticky event word records any disagreement between what was commanded and what was observed. It also records that an emergency open occurred. A host read clears the event word.

An emergency input opens the valve for the longest allowed window. It works without the host arm bit and without any host command. Every input and output is a plain level or single-cycle pulse. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `valve_seq`

## Requirements
- R1: After an accepted request from idle, `sw_supply` is high alone for exactly SETTLE_MS·TICKS_PER_MS cycles before `sw_act` rises; `sw_act` is never high while `sw_supply` is low.
- R2: When the open window ends, `sw_act` falls first and `sw_supply` stays high for exactly SETTLE_MS·TICKS_PER_MS further cycles, then falls.
- R3: `sw_act` stays high for T·TICKS_PER_MS cycles, where T is `open_ms` clamped into [MIN_OPEN_MS, MAX_OPEN_MS].
- R4: A host `open_cmd` has an effect only when `arm` is high in the same cycle; otherwise the switches stay open.
- R5: An accepted request while `sw_act` is high restarts the window: `sw_act` stays high for the new T·TICKS_PER_MS cycles counted from the cycle after the request was sampled.
- R6: `emerg` high is an accepted request regardless of `arm`, with T = MAX_OPEN_MS, and sets event bit 2.
- R7: The debounced position changes only after DEB_LEN consecutive 1 ms samples that all differ from its present value; shorter glitches leave it unchanged.
- R8: `cur_status` bit 0 = supply switch, bit 1 = actuating switch, bit 2 = synchronised comparator, bit 3 = debounced position (1 = open).
- R9: Event bit 0 sets when the comparator disagrees with `sw_act` in idle, or in the open window after its first millisecond. Event bit 1 sets when the debounced position is not open at the moment the window ends.
- R10: Event bits stay set until an `evt_rd` pulse clears them. An event arising in the same cycle as `evt_rd` stays set.
- R11: After reset both switches are open, and `cur_status` and `evt_status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Host enable; must be high for `open_cmd` to be accepted |
| open_cmd | input | 1 | One-cycle host open request |
| open_ms | input | TIME_W | Requested open window in ms, sampled with `open_cmd` |
| emerg | input | 1 | Emergency open request; needs neither `arm` nor `open_cmd` |
| evt_rd | input | 1 | Host read strobe; clears the event word |
| cmp_in | input | 1 | Asynchronous comparator output, 1 = coil energised |
| pos_raw | input | 1 | Raw position contact, 1 = open |
| sw_supply | output | 1 | Supply-connect switch drive |
| sw_act | output | 1 | Actuating switch drive |
| cur_status | output | 4 | Live status word (see R8) |
| evt_status | output | 3 | Sticky event word (see R9, R6) |

## Verification
The bench builds the block with TICKS_PER_MS = 4, MIN_OPEN_MS = 3, MAX_OPEN_MS = 12, SETTLE_MS = 1 and DEB_LEN = 8. At these values a millisecond is four cycles, so both clamp limits, the settle gaps and a window restart can each be measured exactly in a few dozen cycles. The debouncer then needs roughly 32 cycles to accept a change, so the bench can hold a short glitch and a long level change within a short run. The comparator is modelled as the actuating switch looped back. A stuck-low mode of that model, together with direct control of the position contact, triggers each event bit on demand.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CONNECT = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RELEASE = 2'd3
  } vseq_state_e;

  localparam int EV_ELEC  = 0;
  localparam int EV_MECH  = 1;
  localparam int EV_EMERG = 2;
  localparam int EV_W     = 3;
  localparam int CS_W     = 4;
endpackage

// File: rtl/vseq_timer.sv
module vseq_timer #(
  parameter int TICKS_PER_MS = 50000,
  parameter int TIME_W       = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  output logic [TIME_W-1:0] ms_cnt,
  output logic              last_sub
);
  localparam int SUB_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(TICKS_PER_MS - 1);

  logic [SUB_W-1:0]  sub_q;
  logic [TIME_W-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sub_q <= '0;
      ms_q  <= '0;
    end else if (sub_q == SUB_MAX) begin
      sub_q <= '0;
      ms_q  <= ms_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign ms_cnt   = ms_q;
  assign last_sub = (sub_q == SUB_MAX);

  // R3: the sub-millisecond counter never leaves its range
  a_r3_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= SUB_MAX);
endmodule

// File: rtl/vseq_debounce.sv
module vseq_debounce #(
  parameter int DEB_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic raw,
  output logic deb
);
  localparam int CNT_W = $clog2(DEB_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LEN - 1);

  logic             s1_q, s2_q;
  logic             deb_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deb_q <= 1'b0;
      cnt_q <= '0;
    end else if (sample_tick) begin
      if (s2_q != deb_q) begin
        if (cnt_q == CNT_LAST) begin
          deb_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign deb = deb_q;

  // R7: the filtered level moves only on a sample tick
  a_r7_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_q) |-> $past(sample_tick));
endmodule

// File: rtl/vseq_status.sv
module vseq_status
  import vseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sup,
  input  logic            act,
  input  logic            cmp_in,
  input  logic            pos_deb,
  input  logic            chk_elec,
  input  logic            win_end,
  input  logic            emerg,
  input  logic            evt_rd,
  output logic [CS_W-1:0] cur_status,
  output logic [EV_W-1:0] evt_status
);
  logic            c1_q, c2_q;
  logic [EV_W-1:0] evt_q;
  logic [EV_W-1:0] evt_new;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_q <= 1'b0;
      c2_q <= 1'b0;
    end else begin
      c1_q <= cmp_in;
      c2_q <= c1_q;
    end
  end

  always_comb begin
    evt_new           = '0;
    evt_new[EV_ELEC]  = chk_elec && (c2_q != act);
    evt_new[EV_MECH]  = win_end && !pos_deb;
    evt_new[EV_EMERG] = emerg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_rd ? '0 : evt_q) | evt_new;
  end

  assign cur_status = {pos_deb, c2_q, act, sup};
  assign evt_status = evt_q;

  for (genvar i = 0; i < EV_W; i++) begin : g_sticky
    // R10: a set bit survives every cycle without a read strobe
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[i] && !evt_rd) |=> evt_q[i]);
  end
endmodule

// File: rtl/valve_seq.sv
module valve_seq
  import vseq_pkg::*;
#(
  parameter int TICKS_PER_MS = 50000,
  parameter int TIME_W       = 15,
  parameter int MIN_OPEN_MS  = 50,
  parameter int MAX_OPEN_MS  = 30000,
  parameter int SETTLE_MS    = 1,
  parameter int DEB_LEN      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              open_cmd,
  input  logic [TIME_W-1:0] open_ms,
  input  logic              emerg,
  input  logic              evt_rd,
  input  logic              cmp_in,
  input  logic              pos_raw,
  output logic              sw_supply,
  output logic              sw_act,
  output logic [3:0]        cur_status,
  output logic [2:0]        evt_status
);
  localparam logic [TIME_W-1:0] MIN_L    = TIME_W'(MIN_OPEN_MS);
  localparam logic [TIME_W-1:0] MAX_L    = TIME_W'(MAX_OPEN_MS);
  localparam logic [TIME_W-1:0] SETTLE_L = TIME_W'(SETTLE_MS);
  localparam int SMP_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [SMP_W-1:0] SMP_MAX = SMP_W'(TICKS_PER_MS - 1);

  function automatic logic [TIME_W-1:0] clamp_ms(input logic [TIME_W-1:0] v);
    if (v < MIN_L) return MIN_L;
    if (v > MAX_L) return MAX_L;
    return v;
  endfunction

  vseq_state_e       state_q, state_d;
  logic [TIME_W-1:0] lim_q, lim_d;
  logic [TIME_W-1:0] ms_cnt;
  logic              last_sub;
  logic              tmr_clr;
  logic              req;
  logic [TIME_W-1:0] req_time;
  logic              win_end;
  logic              phase_end;
  logic              chk_elec;
  logic              pos_deb;
  logic [SMP_W-1:0]  smp_q;
  logic              smp_tick;

  assign req      = emerg || (open_cmd && arm);
  assign req_time = emerg ? MAX_L : clamp_ms(open_ms);

  always_comb begin
    if (state_q == ST_ACTIVE) phase_end = last_sub && (ms_cnt == lim_q - 1'b1);
    else                      phase_end = last_sub && (ms_cnt == SETTLE_L - 1'b1);
  end

  always_comb begin
    state_d = state_q;
    lim_d   = lim_q;
    tmr_clr = 1'b0;
    win_end = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (req) begin
          state_d = ST_CONNECT;
          lim_d   = req_time;
        end
      end
      ST_CONNECT: begin
        if (req) lim_d = req_time;
        if (phase_end) begin
          state_d = ST_ACTIVE;
          tmr_clr = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (req) begin
          lim_d   = req_time;
          tmr_clr = 1'b1;
        end else if (phase_end) begin
          state_d = ST_RELEASE;
          tmr_clr = 1'b1;
          win_end = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (req) begin
          state_d = ST_ACTIVE;
          lim_d   = req_time;
          tmr_clr = 1'b1;
        end else if (phase_end) begin
          state_d = ST_IDLE;
          tmr_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lim_q   <= MIN_L;
    end else begin
      state_q <= state_d;
      lim_q   <= lim_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || smp_tick) smp_q <= '0;
    else                    smp_q <= smp_q + 1'b1;
  end
  assign smp_tick = (smp_q == SMP_MAX);

  vseq_timer #(.TICKS_PER_MS(TICKS_PER_MS), .TIME_W(TIME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clr),
    .ms_cnt(ms_cnt), .last_sub(last_sub)
  );

  vseq_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk(clk), .rst_n(rst_n), .sample_tick(smp_tick),
    .raw(pos_raw), .deb(pos_deb)
  );

  assign sw_supply = (state_q != ST_IDLE);
  assign sw_act    = (state_q == ST_ACTIVE);
  assign chk_elec  = (state_q == ST_IDLE) || ((state_q == ST_ACTIVE) && (ms_cnt != '0));

  vseq_status u_status (
    .clk(clk), .rst_n(rst_n), .sup(sw_supply), .act(sw_act),
    .cmp_in(cmp_in), .pos_deb(pos_deb), .chk_elec(chk_elec),
    .win_end(win_end), .emerg(emerg), .evt_rd(evt_rd),
    .cur_status(cur_status), .evt_status(evt_status)
  );

  // R1: the actuating switch only closes on an already connected supply
  a_r1_act_after_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_act) |-> $past(sw_supply));
  // R2: the supply disconnects only after the actuating switch has opened
  a_r2_supply_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_supply) |-> $past(!sw_act));
  // R3: the latched window is always inside the clamp range
  a_r3_lim_range: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q >= MIN_L) && (lim_q <= MAX_L));
  // R4: no request in idle without arm or emergency
  a_r4_disarmed_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !arm && !emerg) |=> !sw_supply);
  // R6: an emergency always leaves the valve sequence running
  a_r6_emerg_runs: assert property (@(posedge clk) disable iff (!rst_n)
    emerg |=> sw_supply);
endmodule

// File: tb/valve_seq_test.sv
module valve_seq_test;
  localparam int DIV = 4, TW = 15, MINMS = 3, MAXMS = 12, SETTLE = 1, DEB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, open_cmd = 1'b0, emerg = 1'b0, evt_rd = 1'b0;
  logic [TW-1:0] open_ms = '0;
  logic pos_raw = 1'b0, cmp_stuck = 1'b0;
  logic cmp_in;
  logic sw_supply, sw_act;
  logic [3:0] cur_status;
  logic [2:0] evt_status;

  int errors = 0, checks = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign cmp_in = sw_act & ~cmp_stuck;

  valve_seq #(.TICKS_PER_MS(DIV), .TIME_W(TW), .MIN_OPEN_MS(MINMS),
              .MAX_OPEN_MS(MAXMS), .SETTLE_MS(SETTLE), .DEB_LEN(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .open_cmd(open_cmd), .open_ms(open_ms),
    .emerg(emerg), .evt_rd(evt_rd), .cmp_in(cmp_in), .pos_raw(pos_raw),
    .sw_supply(sw_supply), .sw_act(sw_act),
    .cur_status(cur_status), .evt_status(evt_status)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures the switch sequence and scores window lengths
  int lead = 0, alen = 0, trail = 0;
  bit act_seen = 1'b0, p_act = 1'b0, p_sup = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sw_supply && !sw_act && !act_seen) lead++;
      if (sw_act) begin act_seen = 1'b1; alen++; end
      if (sw_supply && !sw_act && act_seen) trail++;
      if (sw_act && !p_act) check("R1 settle before actuation", lead, SETTLE*DIV);
      if (!sw_act && p_act) begin
        if (exp_q.size() == 0) check("R3 unexpected window", alen, -1);
        else check("R3/R5/R6 window length", alen, exp_q.pop_front());
      end
      if (!sw_supply && p_sup) begin
        check("R2 settle after actuation", trail, SETTLE*DIV);
        lead = 0; alen = 0; trail = 0; act_seen = 1'b0;
      end
      p_act = sw_act;
      p_sup = sw_supply;
    end
  end

  task automatic wait_done();
    @(negedge clk);
    while (!sw_supply) @(negedge clk);
    while (sw_supply) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_open(input int ms, input int exp_len);
    exp_q.push_back(exp_len);
    @(negedge clk);
    open_cmd = 1'b1; open_ms = TW'(ms);
    @(negedge clk);
    open_cmd = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit saw;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 supply after reset", sw_supply, 0);
    check("R11 actuate after reset", sw_act, 0);
    check("R11 cur_status after reset", cur_status, 0);
    check("R11 evt_status after reset", evt_status, 0);
    rst_n = 1'b1;
    pos_raw = 1'b1;
    repeat (80) @(negedge clk);
    check("R8 position bit only", cur_status, 4'b1000);

    // R4: disarmed command is ignored
    open_ms = TW'(5); open_cmd = 1'b1;
    @(negedge clk); open_cmd = 1'b0;
    saw = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (sw_supply) saw = 1'b1; end
    check("R4 disarmed open ignored", saw, 0);

    arm = 1'b1;
    // R3 nominal window plus R8 live status during the window
    exp_q.push_back(5*DIV);
    @(negedge clk); open_cmd = 1'b1; open_ms = TW'(5);
    @(negedge clk); open_cmd = 1'b0;
    while (!sw_act) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R8 status during window", cur_status, 4'b1111);
    while (sw_supply) @(negedge clk);
    repeat (2) @(negedge clk);

    run_open(1, MINMS*DIV);    // R3 clamp up
    run_open(100, MAXMS*DIV);  // R3 clamp down

    // R5: restart during the window
    exp_q.push_back(7 + 5*DIV);
    @(negedge clk); open_cmd = 1'b1; open_ms = TW'(5);
    @(negedge clk); open_cmd = 1'b0;
    while (!sw_act) @(negedge clk);
    repeat (6) @(negedge clk);
    open_cmd = 1'b1;
    @(negedge clk); open_cmd = 1'b0;
    while (sw_supply) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R9 no event on healthy runs", evt_status, 0);

    // R7: short glitch is filtered, long change is accepted
    pos_raw = 1'b0; repeat (8) @(negedge clk); pos_raw = 1'b1;
    repeat (60) @(negedge clk);
    check("R7 glitch filtered", cur_status[3], 1);
    pos_raw = 1'b0; repeat (60) @(negedge clk);
    check("R7 level accepted", cur_status[3], 0);

    // R9: position not open at window end
    run_open(4, 4*DIV);
    check("R9 mechanical event", evt_status, 3'b010);
    @(negedge clk); evt_rd = 1'b1; @(negedge clk); evt_rd = 1'b0;
    check("R10 read clears events", evt_status, 0);
    pos_raw = 1'b1; repeat (60) @(negedge clk);

    // R9: comparator stuck low
    cmp_stuck = 1'b1;
    run_open(4, 4*DIV);
    cmp_stuck = 1'b0;
    check("R9 electrical event", evt_status, 3'b001);

    // R6 + R10: emergency while disarmed, read strobe in the same cycle
    arm = 1'b0;
    exp_q.push_back(MAXMS*DIV);
    @(negedge clk); emerg = 1'b1; evt_rd = 1'b1;
    @(negedge clk); emerg = 1'b0; evt_rd = 1'b0;
    check("R10 same-cycle event kept, old cleared", evt_status, 3'b100);
    wait_done();
    check("R6 emergency event held", evt_status, 3'b100);
    check("R3 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule